// File: doc/BRIEF.md
# Microsecond Timer with Interval and Periodic Interrupts

This block keeps a free-running microsecond count for a small controller. A prescaler divides the system clock into a one-cycle tick every microsecond, and each tick advances a counter that wraps silently at its top value. Software times an event by reading the counter twice and subtracting the two values.

The same tick stream drives two interrupt sources. A down-counter fires after a programmed number of microseconds and reloads itself, so it repeats at that interval. A fixed periodic source fires every 2^PER_LOG2 ticks, which is 1024 µs with the default settings. Each source has a sticky status flag that is cleared by writing 1, and an enable bit that gates its interrupt output.

Software reaches the block through a byte-wide register bus with a combinational read path. Reading the counter's low byte also captures its high byte, so a two-byte read is coherent even when the low byte rolls over between the two accesses.

Top module: `usec_timer`

## Requirements
- R1: While reset is held and right after it, the counter, reload value, control and status registers and both interrupt outputs are all zero.
- R2: The counter advances by one every CLK_PER_US clock cycles. After k rising edges since reset release it holds floor(k / CLK_PER_US) mod 2^CNT_W, and its low byte is read at address 0.
- R3: The counter wraps from all ones to zero and then keeps counting.
- R4: A read at address 0 captures counter bits 15:8 at the end of that cycle. A later read at address 1 returns the captured byte, even if the counter has moved since.
- R5: Status bit 1 (the periodic flag, address 5) is set on the tick that brings the counter's low PER_LOG2 bits to zero.
- R6: Once control bit 0 (address 4) is 1, status bit 0 (the interval flag) is set on the N-th tick after the edge that wrote the enable, and then again every N ticks. N is the reload value, with bits 7:0 at address 2 and bits 15:8 at address 3.
- R7: A reload value of zero acts as one, so the interval flag is set on every tick.
- R8: Writing 1 to a status bit clears it and writing 0 leaves it unchanged. If a set and a clear fall in the same cycle, the set wins.
- R9: irq_interval equals status bit 0 AND control bit 0. irq_period equals status bit 1 AND control bit 1. The periodic flag is set whether or not its enable is on.
- R10: While control bit 0 is 0, the interval down-counter follows the reload value and never sets its flag. Each enable starts a fresh full interval.
- R11: The reload and control registers read back what was written. Reload bits at or above IVL_W read as zero, and control bits 7:2 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| irq_interval | output | 1 | Interval interrupt request |
| irq_period | output | 1 | Periodic interrupt request |

## Verification
The bench builds the block with CLK_PER_US=2, CNT_W=12, IVL_W=10 and PER_LOG2=4. A full counter wrap then takes 8192 cycles, so every counter value and every low-byte rollover is read back as a coherent pair. The periodic source fires every 32 cycles, which leaves room to line a clear write up exactly with a set. The small prescaler also allows a sweep of every reload value from 0 to 40, plus one value that uses the high reload byte. Each run checks the expiry cycles against arithmetic on the edge count since reset.

// File: rtl/usec_timer_pkg.sv
package usec_timer_pkg;
  localparam int unsigned BUS_AW = 3;
  localparam int unsigned BUS_DW = 8;

  localparam logic [BUS_AW-1:0] REG_CNT_LO = 3'd0;
  localparam logic [BUS_AW-1:0] REG_CNT_HI = 3'd1;
  localparam logic [BUS_AW-1:0] REG_RLD_LO = 3'd2;
  localparam logic [BUS_AW-1:0] REG_RLD_HI = 3'd3;
  localparam logic [BUS_AW-1:0] REG_CTRL   = 3'd4;
  localparam logic [BUS_AW-1:0] REG_STAT   = 3'd5;

  localparam int unsigned BIT_IVL = 0;
  localparam int unsigned BIT_PER = 1;
  localparam int unsigned NSRC    = 2;
endpackage

// File: rtl/usec_prescaler.sv
module usec_prescaler #(
  parameter int unsigned DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] div_q, div_d;

  assign tick = (div_q == LAST);

  always_comb begin
    div_d = tick ? '0 : div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end
endmodule

// File: rtl/usec_free_counter.sv
module usec_free_counter #(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned PER_LOG2 = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt,
  output logic             per_evt
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign cnt     = cnt_q;
  assign per_evt = tick & (&cnt_q[PER_LOG2-1:0]);

  always_comb begin
    cnt_d = cnt_q;
    if (tick) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/usec_interval.sv
module usec_interval #(
  parameter int unsigned IVL_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             en,
  input  logic [IVL_W-1:0] reload,
  output logic             expire
);
  logic [IVL_W-1:0] left_q, left_d;

  assign expire = en & tick & (left_q <= IVL_W'(1));

  always_comb begin
    left_d = left_q;
    if (!en)         left_d = reload;
    else if (expire) left_d = reload;
    else if (tick)   left_d = left_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) left_q <= '0;
    else        left_q <= left_d;
  end
endmodule

// File: rtl/usec_timer.sv
module usec_timer
  import usec_timer_pkg::*;
#(
  parameter int unsigned CLK_PER_US = 12,
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned IVL_W      = 16,
  parameter int unsigned PER_LOG2   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [BUS_DW-1:0] bus_wdata,
  output logic [BUS_DW-1:0] bus_rdata,
  output logic              irq_interval,
  output logic              irq_period
);
  localparam int unsigned WIDE = 2 * BUS_DW;

  logic             tick, per_evt, ivl_evt;
  logic [CNT_W-1:0] cnt;
  logic [IVL_W-1:0] rld_q, rld_d;
  logic [NSRC-1:0]  ctrl_q, ctrl_d, stat_q, stat_d, clr, set;
  logic [BUS_DW-1:0] hi_q, hi_d;
  logic [WIDE-1:0]  cnt_w, rld_w, rld_new;
  logic             wr_en, rd_en;

  usec_prescaler #(.DIV(CLK_PER_US)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  usec_free_counter #(.CNT_W(CNT_W), .PER_LOG2(PER_LOG2)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt(cnt), .per_evt(per_evt)
  );

  usec_interval #(.IVL_W(IVL_W)) u_ivl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .en(ctrl_q[BIT_IVL]),
    .reload(rld_q), .expire(ivl_evt)
  );

  assign wr_en = bus_sel & bus_wr;
  assign rd_en = bus_sel & ~bus_wr;
  assign cnt_w = WIDE'(cnt);
  assign rld_w = WIDE'(rld_q);

  always_comb begin
    rld_new = rld_w;
    ctrl_d  = ctrl_q;
    clr     = '0;
    hi_d    = hi_q;
    if (wr_en) begin
      case (bus_addr)
        REG_RLD_LO: rld_new[BUS_DW-1:0]    = bus_wdata;
        REG_RLD_HI: rld_new[WIDE-1:BUS_DW] = bus_wdata;
        REG_CTRL:   ctrl_d                 = bus_wdata[NSRC-1:0];
        REG_STAT:   clr                    = bus_wdata[NSRC-1:0];
        default: ;
      endcase
    end
    if (rd_en && bus_addr == REG_CNT_LO) hi_d = cnt_w[WIDE-1:BUS_DW];
    rld_d = rld_new[IVL_W-1:0];
    set            = '0;
    set[BIT_IVL]   = ivl_evt;
    set[BIT_PER]   = per_evt;
    stat_d         = (stat_q & ~clr) | set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rld_q  <= '0;
      ctrl_q <= '0;
      stat_q <= '0;
      hi_q   <= '0;
    end else begin
      rld_q  <= rld_d;
      ctrl_q <= ctrl_d;
      stat_q <= stat_d;
      hi_q   <= hi_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      REG_CNT_LO: bus_rdata = cnt_w[BUS_DW-1:0];
      REG_CNT_HI: bus_rdata = hi_q;
      REG_RLD_LO: bus_rdata = rld_w[BUS_DW-1:0];
      REG_RLD_HI: bus_rdata = rld_w[WIDE-1:BUS_DW];
      REG_CTRL:   bus_rdata = BUS_DW'(ctrl_q);
      REG_STAT:   bus_rdata = BUS_DW'(stat_q);
      default:    bus_rdata = '0;
    endcase
  end

  assign irq_interval = stat_q[BIT_IVL] & ctrl_q[BIT_IVL];
  assign irq_period   = stat_q[BIT_PER] & ctrl_q[BIT_PER];
endmodule

// File: rtl/usec_timer_chk.sv
module usec_timer_chk
  import usec_timer_pkg::*;
#(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned PER_LOG2 = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [BUS_AW-1:0] bus_addr,
  input logic [NSRC-1:0]   wd_low,
  input logic              tick,
  input logic [CNT_W-1:0]  cnt,
  input logic [NSRC-1:0]   stat_q,
  input logic [NSRC-1:0]   ctrl_q,
  input logic              irq_interval,
  input logic              irq_period
);
  assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != $past(cnt)) |-> ($past(tick) && cnt == CNT_W'($past(cnt) + 1'b1)));

  assert_cnt_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tick) && $past(cnt) == '1) |-> (cnt == '0));

  assert_per_align_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q[BIT_PER]) |-> (cnt[PER_LOG2-1:0] == '0));

  assert_ivl_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q[BIT_IVL]) |-> $past(ctrl_q[BIT_IVL]));

  assert_ivl_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat_q[BIT_IVL]) |->
      $past(bus_sel && bus_wr && bus_addr == REG_STAT && wd_low[BIT_IVL]));

  assert_per_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat_q[BIT_PER]) |->
      $past(bus_sel && bus_wr && bus_addr == REG_STAT && wd_low[BIT_PER]));

  assert_per_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[BIT_PER] |-> !irq_period);

  assert_ivl_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[BIT_IVL] |-> !irq_interval);
endmodule

bind usec_timer usec_timer_chk #(.CNT_W(CNT_W), .PER_LOG2(PER_LOG2)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .wd_low(bus_wdata[1:0]), .tick(tick), .cnt(cnt),
  .stat_q(stat_q), .ctrl_q(ctrl_q), .irq_interval(irq_interval),
  .irq_period(irq_period)
);

// File: tb/sim_usec_timer.sv
module sim_usec_timer;
  localparam int P   = 2;
  localparam int CW  = 12;
  localparam int IW  = 10;
  localparam int PL  = 4;
  localparam int PER = P * (1 << PL);
  localparam int MOD = 1 << CW;

  localparam logic [2:0] A_CLO = 3'd0, A_CHI = 3'd1, A_RLO = 3'd2,
                         A_RHI = 3'd3, A_CTL = 3'd4, A_STA = 3'd5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq_interval, irq_period;

  int nchk = 0, nerr = 0, ec = 0;

  always #2 clk = ~clk;
  always @(posedge clk) if (rst_n) ec <= ec + 1;

  usec_timer #(.CLK_PER_US(P), .CNT_W(CW), .IVL_W(IW), .PER_LOG2(PL)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_interval(irq_interval), .irq_period(irq_period)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual=%0d expected=%0d (edge %0d)", req, act, exp, ec);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output int d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = int'(bus_rdata);
  endtask

  task automatic run_ivl(input int n);
    int neff, w, nxt, hits, v;
    neff = (n == 0) ? 1 : n;
    wr_reg(A_CTL, 8'h00);
    wr_reg(A_STA, 8'h03);
    wr_reg(A_RLO, 8'(n));
    wr_reg(A_RHI, 8'(n >> 8));
    repeat (3) begin
      rd_reg(A_STA, v);
      chk("R10", v & 1, 0);
      chk("R10", int'(irq_interval), 0);
    end
    wr_reg(A_CTL, 8'h01);
    w = ec;
    nxt = (w / P + 1) * P + (neff - 1) * P;
    hits = 0;
    while (hits < 3) begin
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = A_STA;
      #1 v = int'(bus_rdata) & 1;
      if (ec == nxt) begin
        chk((n == 0) ? "R7" : "R6", v, 1);
        chk("R9", int'(irq_interval), 1);
        bus_wr = 1'b1; bus_wdata = 8'h01;
        hits++;
        nxt += neff * P;
      end else begin
        chk((n == 0) ? "R7" : "R6", v, 0);
        chk("R9", int'(irq_interval), 0);
      end
    end
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    nchk++; nerr++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    int v, lo, hi, k, expv, c, nxt, hits;
    // R1: state while reset is held
    repeat (3) @(negedge clk);
    rd_reg(A_CLO, v); chk("R1", v, 0);
    rd_reg(A_RLO, v); chk("R1", v, 0);
    rd_reg(A_RHI, v); chk("R1", v, 0);
    rd_reg(A_CTL, v); chk("R1", v, 0);
    rd_reg(A_STA, v); chk("R1", v, 0);
    chk("R1", int'(irq_interval), 0);
    chk("R1", int'(irq_period), 0);
    @(negedge clk);
    bus_sel = 1'b0;
    rst_n = 1'b1;
    rd_reg(A_CLO, v); chk("R1", v, 0);

    // R2 R3 R4: full wrap sweep, coherent two-byte reads
    for (int i = 0; i < (MOD * P + 64) / 2; i++) begin
      rd_reg(A_CLO, lo);
      k = ec;
      expv = (k / P) % MOD;
      chk((k / P >= MOD) ? "R3" : "R2", lo, expv & 255);
      rd_reg(A_CHI, hi);
      chk("R4", hi, expv >> 8);
    end

    // R11: readback and masking
    wr_reg(A_RHI, 8'hFF); rd_reg(A_RHI, v); chk("R11", v, 8'h03);
    wr_reg(A_RLO, 8'hA5); rd_reg(A_RLO, v); chk("R11", v, 8'hA5);
    wr_reg(A_CTL, 8'hFC); rd_reg(A_CTL, v); chk("R11", v, 0);
    wr_reg(A_CTL, 8'h00);

    // R6 R7 R9 R10: reload sweep
    for (int n = 0; n <= 40; n++) run_ivl(n);
    run_ivl(700);
    wr_reg(A_CTL, 8'h00);

    // R5 R9: periodic source enabled
    wr_reg(A_CTL, 8'h02);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_STA; bus_wdata = 8'h03;
    c = ec;
    nxt = (c / PER + 1) * PER;
    hits = 0;
    while (hits < 4) begin
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = A_STA;
      #1 v = (int'(bus_rdata) >> 1) & 1;
      if (ec == nxt) begin
        chk("R5", v, 1);
        chk("R9", int'(irq_period), 1);
        bus_wr = 1'b1; bus_wdata = 8'h02;
        hits++;
        nxt += PER;
      end else begin
        chk("R5", v, 0);
        chk("R9", int'(irq_period), 0);
      end
    end

    // R9: flag sets with enable off, output stays low
    wr_reg(A_CTL, 8'h00);
    wr_reg(A_STA, 8'h02);
    repeat (PER + 2) @(negedge clk);
    rd_reg(A_STA, v);
    chk("R9", (v >> 1) & 1, 1);
    chk("R9", int'(irq_period), 0);

    // R8: write 0 leaves flag set
    wr_reg(A_STA, 8'h00);
    rd_reg(A_STA, v); chk("R8", (v >> 1) & 1, 1);
    // R8: clear works
    wr_reg(A_STA, 8'h02);
    rd_reg(A_STA, v); chk("R8", (v >> 1) & 1, 0);
    // R8: set wins over a clear in the same cycle
    do begin
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
    end while (((ec + 1) % PER) != 0);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_STA; bus_wdata = 8'h02;
    rd_reg(A_STA, v); chk("R8", (v >> 1) & 1, 1);
    wr_reg(A_STA, 8'h02);
    rd_reg(A_STA, v); chk("R8", (v >> 1) & 1, 0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule